// File: doc/BRIEF.md
# Timed Digital Pattern Sequencer

The block drives a parallel group of digital trigger lines (eight by default) through a list of patterns held in a small internal table. Each table entry holds a bit pattern and a switch time. The switch time is an absolute count of clock ticks from the start of a run. It is not a duration. A host fills the table through a plain write port that carries address, pattern, time and a write enable. It also presents the number of entries to play.

A rising edge on the asynchronous start input is synchronised and then detected. This opens a run. A tick counter starts from zero and is compared with the time of the current entry. When the counter reaches that time, the whole output word is loaded from one register on a single clock edge, so the lines never skew against each other.

After the last entry has been shown, the outputs fall back to a fixed idle pattern and a one-cycle completion pulse is raised. Between runs the idle pattern is driven at all times. The time field is 40 bits wide, so long runs are possible at full clock resolution.

Top module: `pattern_sequencer`

## Requirements
- R1: During and after reset, `pattern_o` equals `IDLE_PATTERN`, and `running_o` and `done_o` are low.
- R2: A rising edge on `start_i` passes through `SYNC_STAGES` flops and an edge detector. With a non-zero entry count, `running_o` goes high `SYNC_STAGES + 1` clock edges after the first edge that samples `start_i` high.
- R3: The pattern of entry k is shown on `pattern_o` exactly `time_k + 1` cycles after `running_o` rises, so an entry at time zero appears on the very next cycle. All bits of the word change on the same edge.
- R4: The entry count `count_i` is sampled only when a run starts. Values above `DEPTH` are clamped to `DEPTH`. Only entries 0 to count-1 are played, and a change of `count_i` during a run has no effect.
- R5: The final entry is shown for exactly one cycle. In the next cycle `pattern_o` returns to `IDLE_PATTERN`, `running_o` drops, and `done_o` is high for that one cycle only.
- R6: An entry whose time is not later than the time at which the previous entry was applied is shown one cycle after the previous entry.
- R7: A new rising edge on `start_i` during a run is ignored. A start level that stays high after a run ends does not begin a new run.
- R8: A start edge while `count_i` is zero leaves the block idle.
- R9: A cycle with `wr_en_i` high stores `wr_pat_i` and `wr_time_i` at `wr_addr_i`. Stored entries persist and can be replayed by later runs without being written again.
- R10: Whenever `running_o` is low, `pattern_o` equals `IDLE_PATTERN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock; one tick of schedule time |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Asynchronous start request, rising edge opens a run |
| count_i | input | $clog2(DEPTH+1) | Number of entries to play, sampled at run start |
| wr_en_i | input | 1 | Table write enable |
| wr_addr_i | input | $clog2(DEPTH) | Table entry index for a write |
| wr_pat_i | input | PAT_W | Pattern to store |
| wr_time_i | input | TIME_W | Absolute switch time in ticks to store |
| pattern_o | output | PAT_W | Registered output word |
| running_o | output | 1 | High while a run is in progress |
| done_o | output | 1 | One-cycle pulse when a run completes |

## Verification
The bench builds the block with `DEPTH` = 8 and `IDLE_PATTERN` = 8'hA5, and keeps `PAT_W` = 8, `TIME_W` = 40 and `SYNC_STAGES` = 2. The shallow table means a run using every entry, and a count above the table size that has to be clamped, both finish in a few dozen cycles. The non-zero idle value makes the return to idle distinct from a cleared register. Schedules with short tick times let the expected word be predicted in every cycle of each run, including late entries, a retrigger in the middle of a run and a held start level.

// File: rtl/seq_pkg.sv
// Shared definitions for the timed pattern sequencer.
// Assumes: consumers import the package; no parameter-dependent types live here.
package seq_pkg;

    // Run-control states of the sequencer.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // idle pattern driven, waiting for a start edge
        ST_RUN  = 2'd1,   // comparing tick counter against current entry
        ST_LAST = 2'd2    // final entry shown, closing the run next edge
    } seq_state_e;

endpackage

// File: rtl/seq_trigger_sync.sv
// Brings an asynchronous start line into the clock domain and emits a
// one-cycle pulse on its rising edge.
// Assumes: STAGES >= 2; the input is held high for at least one clock period.
module seq_trigger_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Shift the raw input through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], async_i};
    end

    // Remember the last synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[STAGES-1];
    end

    assign rise_o = sync_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/seq_entry_store.sv
// Table of schedule entries: a pattern and an absolute switch time each.
// One synchronous write port, one combinational read port.
// Assumes: DEPTH small enough for flop storage; contents undefined until written.
module seq_entry_store #(
    parameter int DEPTH  = 16,
    parameter int PAT_W  = 8,
    parameter int TIME_W = 40,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              wr_en_i,
    input  logic [AW-1:0]     wr_addr_i,
    input  logic [PAT_W-1:0]  wr_pat_i,
    input  logic [TIME_W-1:0] wr_time_i,
    input  logic [AW-1:0]     rd_addr_i,
    output logic [PAT_W-1:0]  rd_pat_o,
    output logic [TIME_W-1:0] rd_time_o
);

    logic [PAT_W-1:0]  pat_mem  [DEPTH];
    logic [TIME_W-1:0] time_mem [DEPTH];

    // Store one entry per write strobe.
    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            pat_mem[wr_addr_i]  <= wr_pat_i;
            time_mem[wr_addr_i] <= wr_time_i;
        end
    end

    // Present the entry selected by the sequencer.
    always_comb begin
        rd_pat_o  = pat_mem[rd_addr_i];
        rd_time_o = time_mem[rd_addr_i];
    end

endmodule

// File: rtl/seq_tick_counter.sv
// Run-time tick counter: held at zero while cleared, counts up while enabled,
// saturates at its maximum so a very long run cannot wrap and re-match.
// Assumes: clear has priority over enable.
module seq_tick_counter #(
    parameter int TIME_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              en_i,
    output logic [TIME_W-1:0] tick_o
);

    // Advance, hold or clear the tick count.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i)              tick_o <= '0;
        else if (en_i && (tick_o != '1))    tick_o <= tick_o + TIME_W'(1);
    end

endmodule

// File: rtl/pattern_sequencer.sv
// Timed digital pattern sequencer top. On a synchronised start edge it plays
// entries 0..count-1 of the table, loading each entry's pattern into the
// output register once the tick counter reaches the entry's absolute time.
// The last entry is held one cycle, then the idle pattern returns with a
// one-cycle done pulse.
// Assumes: host does not rewrite entries of an active run; times are
// normally increasing (late entries play on consecutive cycles).
module pattern_sequencer #(
    parameter int              DEPTH        = 16,
    parameter int              PAT_W        = 8,
    parameter int              TIME_W       = 40,
    parameter int              SYNC_STAGES  = 2,
    parameter logic [PAT_W-1:0] IDLE_PATTERN = '0,
    localparam int             AW           = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int             CW           = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CW-1:0]     count_i,
    input  logic              wr_en_i,
    input  logic [AW-1:0]     wr_addr_i,
    input  logic [PAT_W-1:0]  wr_pat_i,
    input  logic [TIME_W-1:0] wr_time_i,
    output logic [PAT_W-1:0]  pattern_o,
    output logic              running_o,
    output logic              done_o
);
    import seq_pkg::*;

    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    seq_state_e        state_q;
    logic              trig_rise;
    logic [AW-1:0]     idx_q;
    logic [CW-1:0]     len_q;
    logic [PAT_W-1:0]  cur_pat;
    logic [TIME_W-1:0] cur_time;
    logic [TIME_W-1:0] tick;
    logic              due;
    logic              is_last;
    logic [CW-1:0]     len_eff;

    seq_trigger_sync #(.STAGES(SYNC_STAGES)) trig_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (start_i),
        .rise_o  (trig_rise)
    );

    seq_entry_store #(.DEPTH(DEPTH), .PAT_W(PAT_W), .TIME_W(TIME_W)) store_i (
        .clk       (clk),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_pat_i  (wr_pat_i),
        .wr_time_i (wr_time_i),
        .rd_addr_i (idx_q),
        .rd_pat_o  (cur_pat),
        .rd_time_o (cur_time)
    );

    seq_tick_counter #(.TIME_W(TIME_W)) tick_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (state_q == ST_IDLE),
        .en_i    (state_q == ST_RUN),
        .tick_o  (tick)
    );

    // Decode the current entry: due when its time is reached or passed.
    always_comb begin
        due     = (tick >= cur_time);
        is_last = ((CW'(idx_q) + CW'(1)) == len_q);
        len_eff = (count_i > DEPTH_C) ? DEPTH_C : count_i;
    end

    // Run control, entry index, output word and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            idx_q     <= '0;
            len_q     <= '0;
            pattern_o <= IDLE_PATTERN;
            running_o <= 1'b0;
            done_o    <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (trig_rise && (count_i != '0)) begin
                        state_q   <= ST_RUN;
                        idx_q     <= '0;
                        len_q     <= len_eff;
                        running_o <= 1'b1;
                    end
                end
                ST_RUN: begin
                    if (due) begin
                        pattern_o <= cur_pat;
                        if (is_last) state_q <= ST_LAST;
                        else         idx_q   <= idx_q + AW'(1);
                    end
                end
                ST_LAST: begin
                    state_q   <= ST_IDLE;
                    pattern_o <= IDLE_PATTERN;
                    running_o <= 1'b0;
                    done_o    <= 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/seq_checker.sv
// Property checker for the pattern sequencer, attached by bind.
// Assumes: reset is synchronous and active low.
module seq_checker #(
    parameter int               PAT_W        = 8,
    parameter int               AW           = 4,
    parameter int               CW           = 5,
    parameter logic [PAT_W-1:0] IDLE_PATTERN = '0
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PAT_W-1:0] pattern_o,
    input logic             running_o,
    input logic             done_o,
    input logic             trig_rise,
    input logic [AW-1:0]    idx_q,
    input logic [CW-1:0]    len_q
);

    assert_idle_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !running_o |-> (pattern_o == IDLE_PATTERN));

    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_end_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running_o) |-> done_o);

    assert_done_after_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!running_o && $past(running_o)));

    assert_start_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running_o) |-> $past(trig_rise));

    assert_index_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        running_o |-> (CW'(idx_q) < len_q));

endmodule

bind pattern_sequencer seq_checker #(
    .PAT_W(PAT_W), .AW(AW), .CW(CW), .IDLE_PATTERN(IDLE_PATTERN)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pattern_o (pattern_o),
    .running_o (running_o),
    .done_o    (done_o),
    .trig_rise (trig_rise),
    .idx_q     (idx_q),
    .len_q     (len_q)
);

// File: tb/pattern_sequencer_tb_top.sv
// Scoreboard bench: driver tasks push per-cycle expectations, a monitor pops
// and compares them at the falling edge.
module pattern_sequencer_tb_top;

    localparam int         DEPTH  = 8;
    localparam int         PAT_W  = 8;
    localparam int         TIME_W = 40;
    localparam int         AW     = $clog2(DEPTH);
    localparam int         CW     = $clog2(DEPTH + 1);
    localparam logic [7:0] IDLE   = 8'hA5;

    typedef struct {
        int         cyc;
        logic [7:0] pat;
        bit         run;
        bit         done;
        string      tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [CW-1:0]     count_i = '0;
    logic              wr_en_i = 1'b0;
    logic [AW-1:0]     wr_addr_i = '0;
    logic [PAT_W-1:0]  wr_pat_i = '0;
    logic [TIME_W-1:0] wr_time_i = '0;
    logic [PAT_W-1:0]  pattern_o;
    logic              running_o;
    logic              done_o;

    int   cyc = 0;
    int   n_chk = 0;
    int   n_bad = 0;
    exp_t q[$];
    int   t_arr[DEPTH];
    logic [7:0] p_arr[DEPTH];

    pattern_sequencer #(
        .DEPTH(DEPTH), .PAT_W(PAT_W), .TIME_W(TIME_W),
        .SYNC_STAGES(2), .IDLE_PATTERN(IDLE)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .count_i(count_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_pat_i(wr_pat_i),
        .wr_time_i(wr_time_i), .pattern_o(pattern_o), .running_o(running_o),
        .done_o(done_o)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare the head of the scoreboard in its cycle.
    always @(negedge clk) begin
        if (q.size() > 0 && q[0].cyc <= cyc) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if (e.cyc != cyc) begin
                n_bad++;
                $display("FAIL %s: expectation for cycle %0d missed (now %0d)", e.tag, e.cyc, cyc);
            end else if (pattern_o !== e.pat || running_o !== e.run || done_o !== e.done) begin
                n_bad++;
                $display("FAIL %s: cycle %0d actual pat=%h run=%b done=%b expected pat=%h run=%b done=%b",
                         e.tag, cyc, pattern_o, running_o, done_o, e.pat, e.run, e.done);
            end
        end
    end

    task automatic push(input int c, input logic [7:0] p, input bit r, input bit d, input string tag);
        exp_t e;
        e.cyc = c; e.pat = p; e.run = r; e.done = d; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic write_entry(input int a, input logic [7:0] p, input int t);
        @(negedge clk);
        wr_en_i   = 1'b1;
        wr_addr_i = AW'(a);
        wr_pat_i  = p;
        wr_time_i = TIME_W'(t);
        @(negedge clk);
        wr_en_i   = 1'b0;
    endtask

    task automatic load(input int n);
        for (int k = 0; k < n; k++) write_entry(k, p_arr[k], t_arr[k]);
    endtask

    task automatic expect_idle(input int ncyc, input string tag);
        for (int c = 1; c <= ncyc; c++) push(cyc + c, IDLE, 1'b0, 1'b0, tag);
    endtask

    task automatic drain();
        while (q.size() > 0) @(negedge clk);
    endtask

    // Raise start, then push the whole expected run for `used` entries.
    task automatic start_run(input int used, input string tag);
        int e[DEPTH];
        int c0;
        int last;
        @(negedge clk);
        start_i = 1'b1;
        c0 = cyc;
        for (int k = 0; k < used; k++) begin
            // R6: a late entry follows its predecessor by one cycle
            e[k] = (k == 0) ? t_arr[0] : ((t_arr[k] > e[k-1]) ? t_arr[k] : e[k-1] + 1);
        end
        last = e[used-1];
        for (int rel = 1; rel <= last + 9; rel++) begin
            logic [7:0] p;
            string      tg;
            p = IDLE;
            for (int k = 0; k < used; k++) if (rel >= 4 + e[k] && rel <= 4 + last) p = p_arr[k];
            if (rel < 3)               tg = "R10";
            else if (rel == 3)         tg = "R2";
            else if (rel == 5 + last)  tg = "R5";
            else if (rel > 5 + last)   tg = "R7";
            else                       tg = tag;
            push(c0 + rel, p, (rel >= 3 && rel <= 4 + last), (rel == 5 + last), tg);
        end
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not complete, actual hung expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values while reset is held and just after release
        expect_idle(2, "R1");
        drain();
        rst_n = 1'b1;
        expect_idle(3, "R1");
        drain();

        // R3: basic schedule with an entry at time zero
        t_arr[0] = 0;  p_arr[0] = 8'h81;
        t_arr[1] = 3;  p_arr[1] = 8'hC5;
        t_arr[2] = 7;  p_arr[2] = 8'h3C;
        t_arr[3] = 12; p_arr[3] = 8'hFF;
        load(4);
        count_i = CW'(4);
        start_run(4, "R3");
        drain();
        start_i = 1'b0;
        repeat (4) @(negedge clk);

        // R9: stored entries replayed without rewriting; R4 shorter count
        count_i = CW'(2);
        start_run(2, "R9");
        drain();
        start_i = 1'b0;
        repeat (4) @(negedge clk);

        // R4: full table, count above depth clamped to DEPTH
        for (int k = 0; k < DEPTH; k++) begin
            t_arr[k] = 2 + 3 * k + k * k;
            p_arr[k] = 8'(8'h11 * (k + 1) ^ 8'h0F);
        end
        load(DEPTH);
        count_i = CW'(15);
        start_run(DEPTH, "R4");
        drain();
        start_i = 1'b0;
        repeat (4) @(negedge clk);

        // R6: entries whose times are not later than the previous one
        t_arr[0] = 5; p_arr[0] = 8'h01;
        t_arr[1] = 5; p_arr[1] = 8'h02;
        t_arr[2] = 2; p_arr[2] = 8'h04;
        t_arr[3] = 9; p_arr[3] = 8'h08;
        load(4);
        count_i = CW'(4);
        start_run(4, "R6");
        drain();
        start_i = 1'b0;
        repeat (4) @(negedge clk);

        // R7: new start edge and count change during a run are ignored
        t_arr[0] = 0;  p_arr[0] = 8'h5A;
        t_arr[1] = 10; p_arr[1] = 8'h3F;
        t_arr[2] = 20; p_arr[2] = 8'hC0;
        t_arr[3] = 30; p_arr[3] = 8'h00;
        load(4);
        count_i = CW'(4);
        start_run(4, "R7");
        repeat (8) @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        start_i = 1'b1;
        repeat (3) @(negedge clk);
        count_i = CW'(1);
        drain();
        start_i = 1'b0;
        repeat (4) @(negedge clk);

        // R8: start edge with zero count leaves the block idle
        count_i = '0;
        @(negedge clk);
        start_i = 1'b1;
        expect_idle(12, "R8");
        drain();
        start_i = 1'b0;
        repeat (2) @(negedge clk);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule